// File: doc/BRIEF.md
# Sleep Mode Entry/Exit Controller

This block moves a small processor core into a low-power sleep state and brings it back out. A decoded sleep strobe from the instruction path is the only way in. On the accepting cycle the block pulses a watchdog clear, and on the next cycle it gates the core clock off, sets the time-out flag and clears the power-down flag. The watchdog counter is outside the block and keeps running while the core sleeps.

Three events end a sleep: an overflow pulse from the watchdog, a request from the pin-wakeup logic, or the external reset pin. Each of them raises the restart request, which makes the program counter load its top address, the same vector used at reset. A sticky two-bit code records which event caused the most recent exit, so the restarted code can read it. The external reset pin is asynchronous. It passes through a synchronizer, then overrides every other cause and restores both status flags. A watchdog overflow while the core is awake is not a wakeup. It leaves on a separate watchdog-reset output.

Top module: `sleep_seq`

## Requirements
- R1: Sleep is entered only on a clock edge where sleep_req is high, the block is awake and the synchronized external reset is inactive. No other input combination causes entry.
- R2: core_clk_en is 0 in every cycle spent asleep and 1 otherwise. While asleep, sleep_req has no effect.
- R3: wdt_clr is high, combinationally, in exactly the cycle in which a sleep strobe is accepted, and is low at all other times.
- R4: In the first sleep cycle, flag_to reads 1 and flag_pd reads 0.
- R5: A wdt_ovf or wake_req pulse while asleep exits sleep at the next edge and raises restart_req for exactly one cycle. If both arrive together, wdt_ovf wins. exit_cause becomes 2'b01 for a watchdog exit and 2'b10 for a pin wakeup. A watchdog exit also clears flag_to to 0.
- R6: ext_rst_n low is synchronized through SYNC_STAGES (default 2) flops. Once it is synchronized, restart_req and core_clk_en read 1 while it stays asserted, wdt_clr and wdt_rst are held low, and at the following edge the block is awake with flag_to=1, flag_pd=1 and exit_cause=2'b11, whatever else is asserted.
- R7: While awake and outside external reset, wdt_ovf is passed to wdt_rst in the same cycle. It changes neither the sleep state, nor exit_cause, nor restart_req.
- R8: sleep_req and wake_req high in the same cycle give exactly one sleep cycle, followed by an exit with exit_cause=2'b10.
- R9: exit_cause keeps its value until the next exit. rst_n returns it to 2'b00.
- R10: After rst_n the block is awake: core_clk_en=1, restart_req=0, wdt_clr=0, flag_to=1, flag_pd=1, exit_cause=2'b00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Chip reset, asynchronous, active low |
| ext_rst_n | input | 1 | External reset pin, asynchronous, active low |
| sleep_req | input | 1 | Decoded sleep instruction strobe |
| wdt_ovf | input | 1 | Watchdog overflow pulse |
| wake_req | input | 1 | Pin-wakeup request |
| core_clk_en | output | 1 | Core clock-gate enable |
| wdt_clr | output | 1 | Watchdog clear pulse |
| wdt_rst | output | 1 | Watchdog reset while awake |
| restart_req | output | 1 | Load top-address vector into the program counter |
| flag_to | output | 1 | Time-out status flag |
| flag_pd | output | 1 | Power-down status flag |
| exit_cause | output | 2 | Sticky code of the last exit cause |

## Verification
The bench sweeps all eight combinations of sleep_req, wdt_ovf and wake_req during a sleep cycle. This shows the priority of the watchdog over a pin wakeup, the absence of any response to a repeated sleep strobe, and the value left in the cause code. The same inputs are tried while the core is awake, which separates a pass-through watchdog reset from a wakeup, and with sleep and wakeup raised together, which exposes the one-cycle sleep. An external reset is then asserted during sleep with every other input high. This checks the synchronizer delay, the override and the restored flags.

// File: rtl/sleep_seq.sv
module sleep_seq #(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ext_rst_n,
  input  logic       sleep_req,
  input  logic       wdt_ovf,
  input  logic       wake_req,
  output logic       core_clk_en,
  output logic       wdt_clr,
  output logic       wdt_rst,
  output logic       restart_req,
  output logic       flag_to,
  output logic       flag_pd,
  output logic [1:0] exit_cause
);

  localparam int SW = (SYNC_STAGES < 2) ? 2 : SYNC_STAGES;

  logic [SW-1:0] ers_sync;
  logic          ers;
  logic          asleep;
  logic          early_wake;
  logic          restart_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) ers_sync <= '0;
    else        ers_sync <= {ers_sync[SW-2:0], ~ext_rst_n};

  assign ers = ers_sync[SW-1];

  assign core_clk_en = ~asleep | ers;
  assign wdt_clr     = ~asleep & ~ers & sleep_req;
  assign wdt_rst     = ~asleep & ~ers & wdt_ovf;
  assign restart_req = restart_q | ers;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      asleep     <= 1'b0;
      early_wake <= 1'b0;
      restart_q  <= 1'b0;
      flag_to    <= 1'b1;
      flag_pd    <= 1'b1;
      exit_cause <= 2'b00;
    end else if (ers) begin
      asleep     <= 1'b0;
      early_wake <= 1'b0;
      restart_q  <= 1'b0;
      flag_to    <= 1'b1;
      flag_pd    <= 1'b1;
      exit_cause <= 2'b11;
    end else begin
      restart_q <= 1'b0;
      if (!asleep) begin
        if (sleep_req) begin
          asleep     <= 1'b1;
          early_wake <= wake_req;
          flag_to    <= 1'b1;
          flag_pd    <= 1'b0;
        end
      end else if (wdt_ovf) begin
        asleep     <= 1'b0;
        early_wake <= 1'b0;
        restart_q  <= 1'b1;
        flag_to    <= 1'b0;
        exit_cause <= 2'b01;
      end else if (wake_req || early_wake) begin
        asleep     <= 1'b0;
        early_wake <= 1'b0;
        restart_q  <= 1'b1;
        exit_cause <= 2'b10;
      end
    end
  end

  // R1
  entry_by_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(asleep) |-> $past(sleep_req));

  // R3
  clr_then_sleep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_clr |=> asleep);

  // R4
  entry_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(asleep) |-> (flag_to && !flag_pd));

  // R5
  restart_from_sleep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (restart_req && !ers) |-> ($past(asleep) && !asleep));

  // R6
  ext_reset_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ers |-> (restart_req && core_clk_en && !wdt_clr && !wdt_rst));

  // R8
  one_cycle_sleep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wdt_clr && wake_req) |=> ##1 !asleep);

endmodule

// File: tb/sleep_seq_tb.sv
module sleep_seq_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0, ext_rst_n = 1'b1;
  logic sleep_req = 1'b0, wdt_ovf = 1'b0, wake_req = 1'b0;
  logic core_clk_en, wdt_clr, wdt_rst, restart_req, flag_to, flag_pd;
  logic [1:0] exit_cause;
  int checks = 0, failures = 0;
  logic [1:0] prev_cause;

  always #2.5 clk = ~clk;

  sleep_seq u_dut (
    .clk(clk), .rst_n(rst_n), .ext_rst_n(ext_rst_n),
    .sleep_req(sleep_req), .wdt_ovf(wdt_ovf), .wake_req(wake_req),
    .core_clk_en(core_clk_en), .wdt_clr(wdt_clr), .wdt_rst(wdt_rst),
    .restart_req(restart_req), .flag_to(flag_to), .flag_pd(flag_pd),
    .exit_cause(exit_cause));

  task automatic chk(input string tag, input logic [1:0] act, input logic [1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic enter_sleep();
    sleep_req = 1'b1; #0.5;
    chk("R3 wdt_clr on entry", wdt_clr, 1);
    tick();
    sleep_req = 1'b0; #0.5;
    chk("R3 wdt_clr single", wdt_clr, 0);
    chk("R2 clk gated", core_clk_en, 0);
    chk("R4 flag_to", flag_to, 1);
    chk("R4 flag_pd", flag_pd, 0);
  endtask

  initial begin
    #200000;
    failures++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    tick(); tick();
    rst_n = 1'b1; #0.5;
    chk("R10 clk_en", core_clk_en, 1);
    chk("R10 restart", restart_req, 0);
    chk("R10 wdt_clr", wdt_clr, 0);
    chk("R10 flag_to", flag_to, 1);
    chk("R10 flag_pd", flag_pd, 1);
    chk("R10 cause", exit_cause, 2'b00);
    tick();
    chk("R1 no entry idle", core_clk_en, 1);
    prev_cause = 2'b00;

    for (int c = 0; c < 8; c++) begin
      enter_sleep();
      wdt_ovf = c[0]; wake_req = c[1]; sleep_req = c[2]; #0.5;
      chk("R2 strobe ignored asleep", wdt_clr, 0);
      chk("R7 no passthrough asleep", wdt_rst, 0);
      tick();
      wdt_ovf = 1'b0; wake_req = 1'b0; sleep_req = 1'b0; #0.5;
      if (c[0] || c[1]) begin
        chk("R5 restart", restart_req, 1);
        chk("R5 clk_en", core_clk_en, 1);
        chk("R5 cause", exit_cause, c[0] ? 2'b01 : 2'b10);
        chk("R5 flag_to", flag_to, c[0] ? 1'b0 : 1'b1);
        tick();
        chk("R5 restart single", restart_req, 0);
      end else begin
        chk("R2 still gated", core_clk_en, 0);
        chk("R5 no restart", restart_req, 0);
        chk("R9 cause sticky", exit_cause, prev_cause);
        wake_req = 1'b1;
        tick();
        wake_req = 1'b0; #0.5;
        chk("R5 wake exit", restart_req, 1);
        chk("R5 wake cause", exit_cause, 2'b10);
        tick();
      end
      prev_cause = exit_cause;
    end

    wdt_ovf = 1'b1; #0.5;
    chk("R7 passthrough", wdt_rst, 1);
    tick();
    wdt_ovf = 1'b0; #0.5;
    chk("R7 stays awake", core_clk_en, 1);
    chk("R7 no restart", restart_req, 0);
    chk("R7 cause kept", exit_cause, prev_cause);
    tick();
    chk("R1 overflow no entry", core_clk_en, 1);

    sleep_req = 1'b1; wake_req = 1'b1;
    tick();
    sleep_req = 1'b0; wake_req = 1'b0; #0.5;
    chk("R8 one sleep cycle", core_clk_en, 0);
    tick();
    chk("R8 exit", restart_req, 1);
    chk("R8 clk_en", core_clk_en, 1);
    chk("R8 cause", exit_cause, 2'b10);
    tick();

    enter_sleep();
    ext_rst_n = 1'b0;
    tick();
    chk("R6 sync delay", core_clk_en, 0);
    chk("R6 sync delay restart", restart_req, 0);
    tick();
    chk("R6 restart held", restart_req, 1);
    chk("R6 clk_en", core_clk_en, 1);
    wdt_ovf = 1'b1; wake_req = 1'b1; sleep_req = 1'b1; #0.5;
    chk("R6 no clr", wdt_clr, 0);
    chk("R6 no wdt_rst", wdt_rst, 0);
    tick();
    chk("R6 cause override", exit_cause, 2'b11);
    chk("R6 flag_to", flag_to, 1);
    chk("R6 flag_pd", flag_pd, 1);
    wdt_ovf = 1'b0; wake_req = 1'b0; sleep_req = 1'b0;
    ext_rst_n = 1'b1;
    tick(); tick();
    chk("R6 release", restart_req, 0);
    chk("R6 awake", core_clk_en, 1);
    chk("R9 cause after ext", exit_cause, 2'b11);

    rst_n = 1'b0; #1;
    chk("R9 cleared by rst_n", exit_cause, 2'b00);
    rst_n = 1'b1;
    tick();

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule